// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and decides which one a processor should service. Each request line feeds a pending bit. Software can also raise a source through a force register and can hide it through a 64-bit mask. Every source has a control byte that holds its priority level, and a zero control byte disables that source. Among the sources that are raised, enabled and unmasked, the one with the highest level wins. When two of them share the highest level, the higher-numbered source wins.

The block drives the winning level and an interrupt vector number to the processor side. Both outputs come from registers. Software reaches the registers through a byte-addressed bus with one write strobe, an address and a combinational read-data return. Two byte-wide ports change the mask one bit at a time, or change the whole mask at once. A software acknowledge location returns the vector currently presented.

The block has no state machine. The selection is a combinational tournament over the 64 sources, and a pipeline register holds its result.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending bit of source n is loaded from `irq_in[n]` on every clock. Reads at 0x00 return pending[63:32] and reads at 0x04 return pending[31:0]. Bus writes to 0x00 and 0x04 leave pending unchanged.
- R2: A source is active when all of the following hold: its pending bit or its force bit is 1, its control byte is nonzero, and its mask bit is 0.
- R3: The winner is the active source with the largest control-byte value. If several active sources share that value, the one with the highest index wins.
- R4: While some source is active, `irq_level` equals the winner's control byte and `irq_vector` equals 64 plus the winner's index. While no source is active, `irq_level` is 0 and `irq_vector` is 24.
- R5: A write to 0x08 loads mask[63:32] from `bus_wdata` and a write to 0x0C loads mask[31:0]. Both halves read back at the same offsets.
- R6: A write to 0x10 loads force[63:32] and a write to 0x14 loads force[31:0]. Both halves read back at the same offsets.
- R7: Offset 0x40+n holds the control byte of source n, for n from 0 to 63. A write stores `bus_wdata[7:0]`, and a read returns the byte zero-extended to 32 bits. A zero byte keeps the source inactive.
- R8: A write to 0x1C sets mask bits. If `bus_wdata[6]` is 1, every mask bit is set. Otherwise only mask bit `bus_wdata[5:0]` is set.
- R9: A write to 0x1D clears mask bits. If `bus_wdata[6]` is 1, the whole mask is cleared. Otherwise only mask bit `bus_wdata[5:0]` is cleared.
- R10: A read at 0xE0 returns the current value of `irq_vector`.
- R11: After reset, the mask is all ones, pending, force and every control byte are 0, `irq_level` is 0 and `irq_vector` is 24.
- R12: Reads at unmapped offsets return 0. Writes to unmapped offsets change no register.
- R13: The outputs are registered. A register written at clock edge k is reflected on the outputs after edge k+1. A change on `irq_in` sampled at edge k is also reflected after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 64 | Level-sensitive request lines, one per source |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_level | output | 8 | Priority level of the winning source, 0 when idle |
| irq_vector | output | 8 | Vector number of the winning source, 24 when idle |

## Verification
The bench builds the block with its default vector base of 64 and idle vector of 24. With these values every possible vector, 24 and 64 to 127, can be compared directly against the bench's own priority scan. Random control bytes are drawn from the small range 0 to 3, so equal levels and disabled sources occur often, and the highest-index tie rule and the enable rule are exercised on almost every step. Directed steps cover the whole-mask set and clear, sources raised only through the force register, ignored pending and unmapped writes, and the two-edge latency from a request line to the outputs.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
    localparam int SRC_N  = 64;
    localparam int IDX_W  = $clog2(SRC_N);
    localparam int LVL_W  = 8;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;
    localparam int VEC_W  = 8;
    localparam int HALF_W = SRC_N / 2;

    localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FRC_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FRC_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MSET    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MCLR    = 8'h1D;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'hE0;

    // bit of a mask-port byte that selects the whole register
    localparam int ALL_BIT = 6;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } cand_t;

    // upper operand always carries the higher source indices,
    // so >= hands ties to the higher index
    function automatic cand_t pick_cand(input cand_t lo_c, input cand_t hi_c);
        if (hi_c.vld && (!lo_c.vld || hi_c.lvl >= lo_c.lvl))
            return hi_c;
        return lo_c;
    endfunction

    function automatic logic in_ctrl_win(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W] == OFS_CTRL[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/irq_src_regs.sv
`timescale 1ns/1ps
module irq_src_regs
    import irq_prio_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SRC_N-1:0]              irq_in,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [SRC_N-1:0]              pend,
    output logic [SRC_N-1:0]              frc,
    output logic [SRC_N-1:0]              mask,
    output logic [SRC_N-1:0][LVL_W-1:0]   ctrl
);
    logic [IDX_W-1:0] sel_idx;
    logic             sel_all;

    assign sel_idx = wdata[IDX_W-1:0];
    assign sel_all = wdata[ALL_BIT];

    // pending tracks the request lines; no bus path reaches it
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= irq_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            frc  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_MASK_HI: mask[SRC_N-1:HALF_W] <= wdata;
                OFS_MASK_LO: mask[HALF_W-1:0]     <= wdata;
                OFS_FRC_HI:  frc[SRC_N-1:HALF_W]  <= wdata;
                OFS_FRC_LO:  frc[HALF_W-1:0]      <= wdata;
                OFS_MSET: begin
                    if (sel_all)
                        mask <= '1;
                    else
                        mask[sel_idx] <= 1'b1;
                end
                OFS_MCLR: begin
                    if (sel_all)
                        mask <= '0;
                    else
                        mask[sel_idx] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_en && in_ctrl_win(addr))
            ctrl[addr[IDX_W-1:0]] <= wdata[LVL_W-1:0];
    end
endmodule

// File: rtl/irq_prio_tree.sv
`timescale 1ns/1ps
module irq_prio_tree
    import irq_prio_pkg::*;
(
    input  logic [SRC_N-1:0]              pend,
    input  logic [SRC_N-1:0]              frc,
    input  logic [SRC_N-1:0]              mask,
    input  logic [SRC_N-1:0][LVL_W-1:0]   ctrl,
    output cand_t                         win
);
    localparam int STAGES = IDX_W;

    logic [SRC_N-1:0] enab;
    logic [SRC_N-1:0] act;
    cand_t            leaf [SRC_N];

    generate
        for (genvar n = 0; n < SRC_N; n++) begin : g_leaf
            assign enab[n]     = |ctrl[n];
            assign act[n]      = (pend[n] | frc[n]) & enab[n] & ~mask[n];
            assign leaf[n].vld = act[n];
            assign leaf[n].lvl = ctrl[n];
            assign leaf[n].idx = IDX_W'(n);
        end
    endgenerate

    // balanced tournament: each stage halves the number of contenders
    always_comb begin
        cand_t work [SRC_N];
        for (int n = 0; n < SRC_N; n++)
            work[n] = leaf[n];
        for (int s = 0; s < STAGES; s++) begin
            for (int n = 0; n < SRC_N; n += (2 << s))
                work[n] = pick_cand(work[n], work[n + (1 << s)]);
        end
        win = work[0];
    end
endmodule

// File: rtl/irq_out_reg.sv
`timescale 1ns/1ps
module irq_out_reg
    import irq_prio_pkg::*;
#(
    parameter int VEC_BASE = 64,
    parameter int VEC_IDLE = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  cand_t            win,
    output logic [LVL_W-1:0] level_q,
    output logic [VEC_W-1:0] vector_q
);
    logic [LVL_W-1:0] level_d;
    logic [VEC_W-1:0] vector_d;

    always_comb begin
        if (win.vld) begin
            level_d  = win.lvl;
            vector_d = VEC_W'(VEC_BASE) + VEC_W'(win.idx);
        end else begin
            level_d  = '0;
            vector_d = VEC_W'(VEC_IDLE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            vector_q <= VEC_W'(VEC_IDLE);
        end else begin
            level_q  <= level_d;
            vector_q <= vector_d;
        end
    end
endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
    import irq_prio_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  logic [SRC_N-1:0]              pend,
    input  logic [SRC_N-1:0]              frc,
    input  logic [SRC_N-1:0]              mask,
    input  logic [SRC_N-1:0][LVL_W-1:0]   ctrl,
    input  logic [VEC_W-1:0]              vector,
    output logic [WORD_W-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (in_ctrl_win(addr)) begin
            rdata = WORD_W'(ctrl[addr[IDX_W-1:0]]);
        end else begin
            case (addr)
                OFS_PEND_HI: rdata = pend[SRC_N-1:HALF_W];
                OFS_PEND_LO: rdata = pend[HALF_W-1:0];
                OFS_MASK_HI: rdata = mask[SRC_N-1:HALF_W];
                OFS_MASK_LO: rdata = mask[HALF_W-1:0];
                OFS_FRC_HI:  rdata = frc[SRC_N-1:HALF_W];
                OFS_FRC_LO:  rdata = frc[HALF_W-1:0];
                OFS_ACK:     rdata = WORD_W'(vector);
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int VEC_BASE = 64,
    parameter int VEC_IDLE = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       irq_in,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        irq_level,
    output logic [7:0]        irq_vector
);
    logic [SRC_N-1:0]            pend_w;
    logic [SRC_N-1:0]            frc_w;
    logic [SRC_N-1:0]            mask_w;
    logic [SRC_N-1:0][LVL_W-1:0] ctrl_w;
    cand_t                       win_w;

    irq_src_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .pend   (pend_w),
        .frc    (frc_w),
        .mask   (mask_w),
        .ctrl   (ctrl_w)
    );

    irq_prio_tree u_tree (
        .pend (pend_w),
        .frc  (frc_w),
        .mask (mask_w),
        .ctrl (ctrl_w),
        .win  (win_w)
    );

    irq_out_reg #(
        .VEC_BASE (VEC_BASE),
        .VEC_IDLE (VEC_IDLE)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .win      (win_w),
        .level_q  (irq_level),
        .vector_q (irq_vector)
    );

    irq_read_mux u_rd (
        .addr   (bus_addr),
        .pend   (pend_w),
        .frc    (frc_w),
        .mask   (mask_w),
        .ctrl   (ctrl_w),
        .vector (irq_vector),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/1ps
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int VEC_BASE = 64,
    parameter int VEC_IDLE = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [SRC_N-1:0]  irq_in,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [SRC_N-1:0]  pend,
    input logic [SRC_N-1:0]  mask,
    input logic [LVL_W-1:0]  irq_level,
    input logic [VEC_W-1:0]  irq_vector
);
    // R1: pending follows the lines whatever the bus does
    assert_pend_track_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend == $past(irq_in));

    // R4: idle level pairs with the idle vector
    assert_idle_vec_R4: assert property (@(posedge clk) disable iff (rst)
        irq_level == '0 |-> irq_vector == VEC_W'(VEC_IDLE));

    // R4: a nonzero level pairs with a source vector
    assert_busy_vec_R4: assert property (@(posedge clk) disable iff (rst)
        irq_level != '0 |-> (irq_vector >= VEC_W'(VEC_BASE)
                          && irq_vector <  VEC_W'(VEC_BASE + SRC_N)));

    // R8
    assert_mset_all_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MSET && bus_wdata[ALL_BIT]) |=> mask == '1);

    assert_mset_one_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MSET && !bus_wdata[ALL_BIT])
        |=> mask[$past(bus_wdata[IDX_W-1:0])]);

    // R9
    assert_mclr_all_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MCLR && bus_wdata[ALL_BIT]) |=> mask == '0);

    assert_mclr_one_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MCLR && !bus_wdata[ALL_BIT])
        |=> !mask[$past(bus_wdata[IDX_W-1:0])]);

    // R11: first cycle out of reset shows the reset values
    assert_rst_vals_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '1 && irq_level == '0
                        && irq_vector == VEC_W'(VEC_IDLE)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
    .VEC_BASE (VEC_BASE),
    .VEC_IDLE (VEC_IDLE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pend       (pend_w),
    .mask       (mask_w),
    .irq_level  (irq_level),
    .irq_vector (irq_vector)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench-side model of the software-visible state
    logic [63:0] m_frc;
    logic [63:0] m_mask;
    logic [7:0]  m_ctrl [64];

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        if (a >= 8'h40 && a < 8'h80) m_ctrl[a - 8'h40] = d[7:0];
        else if (a == 8'h08) m_mask[63:32] = d;
        else if (a == 8'h0C) m_mask[31:0]  = d;
        else if (a == 8'h10) m_frc[63:32]  = d;
        else if (a == 8'h14) m_frc[31:0]   = d;
        else if (a == 8'h1C) begin
            if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
        end else if (a == 8'h1D) begin
            if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
        end
    endfunction

    // reference scan: highest level, later index wins on equal level
    function automatic logic [15:0] ref_out();
        logic [7:0] bl;
        int         bi;
        bl = 8'd0;
        bi = -1;
        for (int i = 0; i < 64; i++) begin
            if ((irq_in[i] | m_frc[i]) && m_ctrl[i] != 8'd0 && !m_mask[i]
                && m_ctrl[i] >= bl) begin
                bl = m_ctrl[i];
                bi = i;
            end
        end
        if (bi < 0) return {8'd0, 8'd24};
        return {bl, 8'(64 + bi)};
    endfunction

    // drive on a falling edge, the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // one more rising edge so the output registers follow the state
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic chk_out(input string tag);
        logic [15:0] e;
        logic [31:0] r;
        e = ref_out();
        chk({tag, " level"},  32'(irq_level),  32'(e[15:8]));
        chk({tag, " vector"}, 32'(irq_vector), 32'(e[7:0]));
        rd(8'hE0, r);
        chk("R10 ack read", r, 32'(e[7:0]));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] keep_lo;
        logic [31:0] keep_hi;
        logic [31:0] keep_f;
        void'($urandom(32'd20240611));
        m_frc  = '0;
        m_mask = '1;
        for (int i = 0; i < 64; i++) m_ctrl[i] = 8'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset values
        chk("R11 level",  32'(irq_level),  32'd0);
        chk("R11 vector", 32'(irq_vector), 32'd24);
        rd(8'h08, r); chk("R11 mask hi", r, 32'hFFFF_FFFF);
        rd(8'h0C, r); chk("R11 mask lo", r, 32'hFFFF_FFFF);
        rd(8'h10, r); chk("R11 force hi", r, 32'd0);
        rd(8'h45, r); chk("R11 ctrl byte", r, 32'd0);

        // R7 and R2: raised, unmasked, but zero control byte stays idle
        irq_in[5] = 1'b1;
        wr(8'h1D, 32'd5);
        settle();
        chk("R7 disabled level", 32'(irq_level), 32'd0);
        wr(8'h45, 32'd3);
        settle();
        chk("R2 single level",  32'(irq_level),  32'd3);
        chk("R4 single vector", 32'(irq_vector), 32'd69);
        rd(8'h45, r); chk("R7 ctrl readback", r, 32'd3);

        // R3 tie goes to the higher index
        irq_in[9] = 1'b1;
        wr(8'h49, 32'd3);
        wr(8'h1D, 32'd9);
        settle();
        chk("R3 tie vector", 32'(irq_vector), 32'd73);
        irq_in[2] = 1'b1;
        wr(8'h42, 32'd5);
        wr(8'h1D, 32'd2);
        settle();
        chk("R3 higher level vector", 32'(irq_vector), 32'd66);
        chk("R3 higher level", 32'(irq_level), 32'd5);

        // R1 pending writes ignored, words readable
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, r); chk("R1 pend lo", r, irq_in[31:0]);
        rd(8'h00, r); chk("R1 pend hi", r, irq_in[63:32]);

        // R6 force raises source 40
        wr(8'h10, 32'h0000_0100);
        wr(8'h68, 32'd7);
        wr(8'h1D, 32'd40);
        settle();
        chk("R6 force vector", 32'(irq_vector), 32'd104);
        rd(8'h10, r); chk("R6 force readback", r, 32'h0000_0100);

        // R8 whole mask set, R9 whole mask clear
        wr(8'h1C, 32'h40);
        settle();
        chk("R8 set all level", 32'(irq_level), 32'd0);
        rd(8'h08, r); chk("R8 set all hi", r, 32'hFFFF_FFFF);
        wr(8'h1D, 32'h40);
        rd(8'h0C, r); chk("R9 clear all lo", r, 32'd0);
        rd(8'h08, r); chk("R9 clear all hi", r, 32'd0);
        wr(8'h1C, 32'd33);
        rd(8'h08, r); chk("R8 set one", r, 32'h0000_0002);

        // R5 word writes
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'h9ABC_DEF0);
        rd(8'h08, r); chk("R5 mask hi", r, 32'h1234_5678);
        rd(8'h0C, r); chk("R5 mask lo", r, 32'h9ABC_DEF0);

        // R12 unmapped offsets
        rd(8'h30, r); chk("R12 unmapped read", r, 32'd0);
        rd(8'hF4, r); chk("R12 unmapped read hi", r, 32'd0);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h08, keep_hi); chk("R12 mask hi kept", keep_hi, 32'h1234_5678);
        rd(8'h0C, keep_lo); chk("R12 mask lo kept", keep_lo, 32'h9ABC_DEF0);
        rd(8'h14, keep_f);  chk("R12 force kept", keep_f, 32'd0);

        // R13 latency: line to output takes two rising edges
        wr(8'h1D, 32'h40);
        irq_in = '0;
        wr(8'h10, 32'd0);
        settle();
        chk("R13 idle before", 32'(irq_level), 32'd0);
        @(negedge clk);
        irq_in[12] = 1'b1;
        wr(8'h4C, 32'd0);
        m_ctrl[12] = 8'd0;
        wr(8'h4C, 32'd6);
        @(negedge clk);
        irq_in[12] = 1'b0;
        irq_in[20] = 1'b1;
        wr(8'h54, 32'd2);
        settle();
        irq_in[20] = 1'b0;
        irq_in[12] = 1'b1;
        @(negedge clk);
        chk("R13 after one edge", 32'(irq_vector), 32'd84);
        @(negedge clk);
        chk("R13 after two edges", 32'(irq_vector), 32'd76);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: irq_in[$urandom_range(0, 63)] = 1'($urandom_range(0, 1));
                1: wr(8'(8'h40 + $urandom_range(0, 63)), 32'($urandom_range(0, 3)));
                2: wr(8'h1D, 32'($urandom_range(0, 63)));
                3: wr(8'h1C, 32'($urandom_range(0, 63)));
                4: wr(($urandom_range(0, 1) != 0) ? 8'h10 : 8'h14, $urandom & $urandom);
                default: irq_in = {$urandom, $urandom};
            endcase
            if (it % 97 == 50) wr(8'h1C, 32'h40);
            if (it % 97 == 60) wr(8'h1D, 32'h40);
            @(negedge clk);
            settle();
            chk_out("R3 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule